// File: doc/BRIEF.md
# Parallel-Bit Execute Packet Splitter

This block sits between the instruction cache and the functional-unit dispatch stage of a wide-issue core. It takes in a 256-bit fetch packet of eight 32-bit operations and cuts it into the instructions (execute packets) that are issued together. Every operation carries a chaining bit. When the bit is set, the following operation belongs to the same instruction. A clear bit closes the instruction. One fetch packet therefore produces a variable number of issue cycles, from one to eight.

Each cycle, the block presents one instruction to dispatch. The instruction is the full packet with the slots that do not belong to it zeroed, plus a slot mask. The ordering of operations within an instruction is free, so the block never reorders slots; it only groups them. The fetch side uses a valid/ready handshake. A new packet is taken in the same cycle that the last instruction of the current packet is issued, so back-to-back packets issue with no bubble. If operation 7 still chains forward, the instruction would spill into the next packet. That case is unsupported: the block closes the instruction at the packet edge and raises an error flag with it.

Top module: `packet_splitter`

## Requirements
- R1: Operation k occupies bits [32k+31:32k] of the packet, and its chaining bit is bit 0 of that operation (1 = the next operation issues in the same cycle, 0 = this operation closes the instruction).
- R2: Each issued instruction covers the operations from the current start slot up to and including the first operation at or after it whose chaining bit is 0, or up to slot 7 if no such operation exists. issue_mask bit k is 1 exactly for the covered slots.
- R3: issue_ops carries each covered operation unchanged in its own slot position, and every uncovered slot is zero.
- R4: The instructions of one packet are issued in slot order, each starting at the slot after the previous one ended. A packet yields one issue more than the count of clear chaining bits among operations 0 to 6.
- R5: issue_span_err is 1 only while the issued instruction contains slot 7 and operation 7 has its chaining bit set. That instruction still ends at slot 7.
- R6: fetch_ready is 1 when no packet is held, or when the instruction containing slot 7 is being issued (issue_valid and issue_ready both 1). It is 0 otherwise.
- R7: While issue_valid is 1 and issue_ready is 0, issue_valid, issue_mask, issue_ops and issue_span_err hold their values into the next cycle.
- R8: During reset, issue_valid is 0 and fetch_ready is 1. The first instruction of the first packet accepted after reset starts at slot 0.
- R9: A packet accepted in the same cycle as the last issue of the previous packet is presented from slot 0 in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_valid | input | 1 | Fetch packet offered |
| fetch_ready | output | 1 | Splitter takes the offered packet this cycle |
| fetch_data | input | 256 | Eight operations, slot 0 in the low word |
| issue_valid | output | 1 | An instruction is presented |
| issue_ready | input | 1 | Dispatch takes the instruction this cycle |
| issue_ops | output | 256 | Packet with uncovered slots zeroed |
| issue_mask | output | 8 | One bit per covered slot |
| issue_span_err | output | 1 | Instruction would continue past slot 7 |

## Verification
The bench builds the block with its default parameters: eight slots of 32 bits, with the chaining bit at position 0. With only eight chaining bits per packet, random packets cover every split shape, including the single-slot and full-packet extremes. Directed packets pin down the all-clear, all-set and four-two-two cases first. A randomly throttled issue_ready exercises holding and back-to-back packet handover against a bench model of the start slot.

// File: rtl/psplit_pkg.sv
package psplit_pkg;
  parameter int unsigned DEF_SLOTS = 8;
  parameter int unsigned DEF_OP_W  = 32;
  parameter int unsigned DEF_CHAIN = 0;
endpackage

// File: rtl/psplit_window.sv
module psplit_window #(
  parameter int unsigned SLOTS = psplit_pkg::DEF_SLOTS,
  parameter int unsigned OP_W  = psplit_pkg::DEF_OP_W,
  parameter int unsigned CHAIN = psplit_pkg::DEF_CHAIN,
  localparam int unsigned IW   = $clog2(SLOTS),
  localparam int unsigned PW   = SLOTS * OP_W
) (
  input  logic [PW-1:0]    pkt,
  input  logic [IW-1:0]    start,
  output logic [SLOTS-1:0] mask,
  output logic [IW-1:0]    end_idx,
  output logic             at_tail,
  output logic             open_tail
);
  logic [SLOTS-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_chain
      assign chain[g] = pkt[g*OP_W + CHAIN];
    end
  endgenerate

  always_comb begin
    logic alive;
    alive   = 1'b0;
    mask    = '0;
    end_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (IW'(i) == start) alive = 1'b1;
      mask[i] = alive;
      if (alive) end_idx = IW'(i);
      if (alive && !chain[i]) alive = 1'b0;
    end
  end

  assign at_tail   = mask[SLOTS-1];
  assign open_tail = mask[SLOTS-1] & chain[SLOTS-1];
endmodule

// File: rtl/psplit_state.sv
module psplit_state #(
  parameter int unsigned SLOTS = psplit_pkg::DEF_SLOTS,
  parameter int unsigned OP_W  = psplit_pkg::DEF_OP_W,
  localparam int unsigned IW   = $clog2(SLOTS),
  localparam int unsigned PW   = SLOTS * OP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_data,
  input  logic          advance,
  input  logic          adv_tail,
  input  logic [IW-1:0] end_idx,
  output logic          held,
  output logic [PW-1:0] pkt_q,
  output logic [IW-1:0] start_q
);
  logic          held_d;
  logic [IW-1:0] start_d;
  logic          start_en;

  always_comb begin
    held_d   = held;
    start_d  = start_q;
    start_en = 1'b0;
    if (advance) begin
      start_en = 1'b1;
      if (adv_tail) begin
        held_d  = 1'b0;
        start_d = '0;
      end else begin
        start_d = end_idx + IW'(1);
      end
    end
    if (load) begin
      held_d   = 1'b1;
      start_d  = '0;
      start_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= 1'b0;
      start_q <= '0;
    end else begin
      held <= held_d;
      if (start_en) start_q <= start_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) pkt_q <= load_data;
  end

  // New packets always begin at slot 0
  p_fresh_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> start_q == '0);
  // A slot-7 issue empties the holder unless a packet is loaded alongside
  p_tail_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
    advance && adv_tail && !load |=> !held);
endmodule

// File: rtl/packet_splitter.sv
module packet_splitter #(
  parameter int unsigned SLOTS = psplit_pkg::DEF_SLOTS,
  parameter int unsigned OP_W  = psplit_pkg::DEF_OP_W,
  parameter int unsigned CHAIN = psplit_pkg::DEF_CHAIN,
  localparam int unsigned IW   = $clog2(SLOTS),
  localparam int unsigned PW   = SLOTS * OP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  output logic             fetch_ready,
  input  logic [PW-1:0]    fetch_data,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [PW-1:0]    issue_ops,
  output logic [SLOTS-1:0] issue_mask,
  output logic             issue_span_err
);
  logic          held;
  logic [PW-1:0] pkt_q;
  logic [IW-1:0] start_q;
  logic [IW-1:0] end_idx;
  logic          at_tail;
  logic          open_tail;
  logic          advance;
  logic [SLOTS-1:0] win_mask;

  psplit_window #(.SLOTS(SLOTS), .OP_W(OP_W), .CHAIN(CHAIN)) u_window (
    .pkt       (pkt_q),
    .start     (start_q),
    .mask      (win_mask),
    .end_idx   (end_idx),
    .at_tail   (at_tail),
    .open_tail (open_tail)
  );

  assign advance     = held & issue_ready;
  assign fetch_ready = ~held | (advance & at_tail);

  psplit_state #(.SLOTS(SLOTS), .OP_W(OP_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fetch_valid & fetch_ready),
    .load_data (fetch_data),
    .advance   (advance),
    .adv_tail  (at_tail),
    .end_idx   (end_idx),
    .held      (held),
    .pkt_q     (pkt_q),
    .start_q   (start_q)
  );

  assign issue_valid    = held;
  assign issue_mask     = held ? win_mask : '0;
  assign issue_span_err = held & open_tail;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      assign issue_ops[g*OP_W +: OP_W] = issue_mask[g] ? pkt_q[g*OP_W +: OP_W] : '0;
    end
  endgenerate

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_ready |=> issue_valid && $stable(issue_mask)
      && $stable(issue_ops) && $stable(issue_span_err));
  p_fetch_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready && issue_valid |-> issue_ready && issue_mask[SLOTS-1]);
  p_span_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_span_err |-> issue_valid && issue_mask[SLOTS-1]);
  p_mask_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> issue_mask != '0);
  p_no_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> issue_valid && issue_mask[0]);
endmodule

// File: tb/packet_splitter_tb.sv
`timescale 1ns/1ps
module packet_splitter_tb;
  localparam int N  = 8;
  localparam int W  = 32;
  localparam int PW = N * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid;
  logic          fetch_ready;
  logic [PW-1:0] fetch_data;
  logic          issue_valid;
  logic          issue_ready;
  logic [PW-1:0] issue_ops;
  logic [N-1:0]  issue_mask;
  logic          issue_span_err;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  packet_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_data(fetch_data), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_ops(issue_ops), .issue_mask(issue_mask), .issue_span_err(issue_span_err)
  );

  task automatic chk(string rq, logic [PW-1:0] act, logic [PW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Covered slots per R2, given the packet and a start slot
  function automatic logic [N-1:0] exp_mask(logic [PW-1:0] p, int s);
    logic [N-1:0] m = '0;
    for (int i = s; i < N; i++) begin
      m[i] = 1'b1;
      if (!p[i*W]) break;
    end
    return m;
  endfunction

  function automatic logic [PW-1:0] exp_ops(logic [PW-1:0] p, logic [N-1:0] m);
    logic [PW-1:0] o = '0;
    for (int i = 0; i < N; i++) if (m[i]) o[i*W +: W] = p[i*W +: W];
    return o;
  endfunction

  function automatic int exp_issues(logic [PW-1:0] p);
    int c = 1;
    for (int i = 0; i < N-1; i++) if (!p[i*W]) c++;
    return c;
  endfunction

  // Packet with the given chaining bits (R1: bit 0 of each word)
  function automatic logic [PW-1:0] make_pkt(logic [N-1:0] chain);
    logic [PW-1:0] p;
    for (int i = 0; i < N; i++) begin
      p[i*W +: W] = $urandom;
      p[i*W] = chain[i];
    end
    return p;
  endfunction

  function automatic logic [N-1:0] pick_chain(int idx);
    case (idx)
      0: return 8'b0000_0000;
      1: return 8'b1111_1111;
      2: return 8'b0101_0111;   // groups of four, two, two
      3: return 8'b1000_0000;
      4: return 8'b0111_1111;
      default: return N'($urandom);
    endcase
  endfunction

  initial begin
    logic [PW-1:0] mpkt;
    logic          mvld;
    int            mstart;
    int            pidx;
    int            issued;
    logic [N-1:0]  m;
    logic          prev_stall;
    logic [PW-1:0] prev_ops;
    logic          prev_handover;
    logic          exp_rdy;

    void'($urandom(32'd20251));
    rst_n = 1'b0; fetch_valid = 1'b0; issue_ready = 1'b0; fetch_data = '0;
    repeat (3) @(negedge clk);
    chk("R8 issue_valid in reset", PW'(issue_valid), PW'(0));
    chk("R8 fetch_ready in reset", PW'(fetch_ready), PW'(1));
    rst_n = 1'b1;
    mvld = 0; mstart = 0; pidx = 0; issued = 0; mpkt = '0;
    prev_stall = 0; prev_ops = '0; prev_handover = 0;

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      m = mvld ? exp_mask(mpkt, mstart) : '0;
      chk("R2 issue_valid", PW'(issue_valid), PW'(mvld));
      chk("R2 issue_mask", PW'(issue_mask), PW'(m));
      if (mvld) begin
        chk("R3 issue_ops", issue_ops, exp_ops(mpkt, m));
        chk("R5 issue_span_err", PW'(issue_span_err), PW'(m[N-1] & mpkt[(N-1)*W]));
      end
      if (prev_stall) chk("R7 held ops", issue_ops, prev_ops);
      if (prev_handover) chk("R9 next packet from slot 0", PW'(issue_mask[0]), PW'(1));

      if (c < 60) begin
        issue_ready = 1'b1; fetch_valid = 1'b1;
      end else begin
        issue_ready = ($urandom % 4) != 0;
        fetch_valid = ($urandom % 3) != 0;
      end
      fetch_data = make_pkt(pick_chain(pidx));
      #1;
      exp_rdy = !mvld || (issue_ready && m[N-1]);
      chk("R6 fetch_ready", PW'(fetch_ready), PW'(exp_rdy));

      prev_stall = mvld && !issue_ready;
      prev_ops = issue_ops;
      prev_handover = 0;
      if (mvld && issue_ready) begin
        issued++;
        if (m[N-1]) begin
          chk("R4 issues per packet", PW'(issued), PW'(exp_issues(mpkt)));
          mvld = 0; mstart = 0;
          prev_handover = fetch_valid;
        end else begin
          for (int i = N-1; i >= 0; i--) if (m[i]) begin mstart = i + 1; break; end
        end
      end
      if (fetch_valid && exp_rdy) begin
        mpkt = fetch_data; mvld = 1; mstart = 0; issued = 0; pidx++;
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule